// File: doc/BRIEF.md
# Level Interrupt Controller with Reset-Button Capture

This block gathers 32 interrupt request lines into one processor interrupt. Software sees two registers on a small 32-bit register bus: a cause word, which shows the state of every source, and a mask word, which enables them. A source counts as pending when its cause bit and its mask bit are both set. The interrupt output is high while any source is pending. The block also reports the index of the pending source that wins, where the lowest number wins.

Most cause bits follow their request line directly, so they clear on their own when the source lets go. One bit records a press of the reset push-button and stays set until software clears it. A second bit shows the live state of the button. A third register lets software request a platform reset, which comes out as a one-cycle pulse.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: The mask word sits at offset 0x04 and reads back what was written. Each of its four bytes is written only when the matching byte strobe `bus_be[k]` is set (byte k covers bits 8k+7..8k).
- R2: The cause word sits at offset 0x00. Every bit other than 1 and 16 equals the current `src_req` bit, so a bit clears as soon as its request drops. `src_req[1]` and `src_req[16]` have no effect.
- R3: Writing ones to the cause word changes none of the level-following bits.
- R4: The button input passes through a two-flop synchronizer. Cause bit 1 becomes 1 three clock edges after the input rises from released to pressed. It then holds even after the button is released, and clears only on a cause write with `bus_be[0]`=1 and `bus_wdata[1]`=1.
- R5: Cause bit 16 reads 0 while the synchronized button is pressed and 1 while it is released. It changes two clock edges after the input does.
- R6: `irq_out` is high exactly when the AND of cause and mask is nonzero.
- R7: `top_valid` equals `irq_out`. `top_idx` gives the lowest-numbered bit set in the AND of cause and mask.
- R8: A write to offset 0x24 with `bus_be[0]`=1 and `bus_wdata[7:0]`=0x00 makes `plat_rst_req` high for the single following cycle. Any other data byte gives no pulse. Offset 0x24 reads as 0.
- R9: After a synchronous reset, the mask is 0, the sticky button bit is 0, and `plat_rst_req` is 0.
- R10: Writing 0 to the mask and then all ones to the cause word leaves `irq_out` and `top_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_req | input | 32 | Level interrupt requests |
| btn_pressed | input | 1 | Reset push-button, high while pressed (asynchronous) |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte strobes |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_out | output | 1 | Processor interrupt |
| top_idx | output | 5 | Index of the winning pending source |
| top_valid | output | 1 | `top_idx` is meaningful |
| plat_rst_req | output | 1 | One-cycle platform reset request |

## Verification
The bench builds the block with its default parameters: a 32-bit data word, an 8-bit offset, the sticky bit at 1 and the live bit at 16. At these values the byte-strobe test can reach all four mask lanes. The priority table can place the only pending source at index 31 as well as at index 0. The sticky bit and the live bit lie in different byte lanes, so a write whose strobe misses lane 0 can be shown to leave the sticky bit set.

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int BTN_BIT  = 1,
  parameter int LIVE_BIT = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [DATA_W-1:0]         src_req,
  input  logic                      btn_pressed,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_we,
  input  logic [DATA_W-1:0]         bus_wdata,
  input  logic [DATA_W/8-1:0]       bus_be,
  output logic [DATA_W-1:0]         bus_rdata,
  output logic                      irq_out,
  output logic [$clog2(DATA_W)-1:0] top_idx,
  output logic                      top_valid,
  output logic                      plat_rst_req
);

  localparam int IDX_W    = $clog2(DATA_W);
  localparam int LANES    = DATA_W / 8;
  localparam int BTN_LANE = BTN_BIT / 8;
  localparam logic [ADDR_W-1:0] CAUSE_OFF = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] MASK_OFF  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] RST_OFF   = ADDR_W'(8'h24);

  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] cause_w;
  logic [DATA_W-1:0] pend_w;
  logic              btn_s1, btn_s2, btn_s3;
  logic              sticky_q;

  wire cause_wr = bus_we && (bus_addr == CAUSE_OFF);
  wire mask_wr  = bus_we && (bus_addr == MASK_OFF);
  wire rst_wr   = bus_we && (bus_addr == RST_OFF);
  wire unused_src = src_req[BTN_BIT] ^ src_req[LIVE_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      btn_s1 <= 1'b0;
      btn_s2 <= 1'b0;
      btn_s3 <= 1'b0;
    end else begin
      btn_s1 <= btn_pressed;
      btn_s2 <= btn_s1;
      btn_s3 <= btn_s2;
    end
  end

  wire press_edge = btn_s2 & ~btn_s3;
  wire sticky_clr = cause_wr & bus_be[BTN_LANE] & bus_wdata[BTN_BIT];

  always_ff @(posedge clk) begin
    if (rst)
      sticky_q <= 1'b0;
    else
      sticky_q <= press_edge | (sticky_q & ~sticky_clr);
  end

  for (genvar b = 0; b < LANES; b++) begin : g_mask_lane
    always_ff @(posedge clk) begin
      if (rst)
        mask_q[8*b +: 8] <= 8'h00;
      else if (mask_wr && bus_be[b])
        mask_q[8*b +: 8] <= bus_wdata[8*b +: 8];
    end
  end

  always_comb begin
    cause_w           = src_req;
    cause_w[BTN_BIT]  = sticky_q;
    cause_w[LIVE_BIT] = ~btn_s2;
  end

  assign pend_w  = cause_w & mask_q;
  assign irq_out = |pend_w;

  always_comb begin
    top_idx   = '0;
    top_valid = 1'b0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (pend_w[i]) begin
        top_idx   = IDX_W'(i);
        top_valid = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      plat_rst_req <= 1'b0;
    else
      plat_rst_req <= rst_wr && bus_be[0] && (bus_wdata[7:0] == 8'h00);
  end

  always_comb begin
    case (bus_addr)
      CAUSE_OFF: bus_rdata = cause_w;
      MASK_OFF:  bus_rdata = mask_q;
      default:   bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/lvl_irq_ctrl_chk.sv
module lvl_irq_ctrl_chk #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int BTN_BIT = 1
) (
  input logic                      clk,
  input logic                      rst,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic                      bus_we,
  input logic [DATA_W-1:0]         bus_wdata,
  input logic [DATA_W/8-1:0]       bus_be,
  input logic [DATA_W-1:0]         cause,
  input logic [DATA_W-1:0]         mask,
  input logic                      irq_out,
  input logic [$clog2(DATA_W)-1:0] top_idx,
  input logic                      top_valid,
  input logic                      plat_rst_req
);

  localparam int BTN_LANE = BTN_BIT / 8;
  localparam logic [ADDR_W-1:0] RST_OFF = ADDR_W'(8'h24);

  logic [DATA_W-1:0] pend;
  logic [DATA_W-1:0] below;
  logic              clr_hit;

  assign pend    = cause & mask;
  assign below   = (DATA_W'(1) << top_idx) - DATA_W'(1);
  assign clr_hit = bus_we && (bus_addr == '0) && bus_be[BTN_LANE] && bus_wdata[BTN_BIT];

  assert_irq_tracks_valid_R7: assert property (@(posedge clk) disable iff (rst)
    irq_out == top_valid);

  assert_top_is_pending_R7: assert property (@(posedge clk) disable iff (rst)
    top_valid |-> pend[top_idx]);

  assert_no_lower_pending_R7: assert property (@(posedge clk) disable iff (rst)
    top_valid |-> ((pend & below) == '0));

  assert_irq_when_pending_R6: assert property (@(posedge clk) disable iff (rst)
    (pend != '0) |-> irq_out);

  assert_sticky_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (cause[BTN_BIT] && !clr_hit) |=> cause[BTN_BIT]);

  assert_rst_pulse_origin_R8: assert property (@(posedge clk) disable iff (rst)
    plat_rst_req |-> $past(bus_we && (bus_addr == RST_OFF) && bus_be[0] && (bus_wdata[7:0] == 8'h00)));

  assert_mask_cleared_R9: assert property (@(posedge clk)
    $past(rst) |-> (mask == '0 && !cause[BTN_BIT] && !plat_rst_req));

endmodule

bind lvl_irq_ctrl lvl_irq_ctrl_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BTN_BIT(BTN_BIT)
) chk_i (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_be(bus_be), .cause(cause_w), .mask(mask_q),
  .irq_out(irq_out), .top_idx(top_idx), .top_valid(top_valid),
  .plat_rst_req(plat_rst_req)
);

// File: tb/lvl_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module lvl_irq_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_req = '0;
  logic        btn_pressed = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;
  logic [4:0]  top_idx;
  logic        top_valid;
  logic        plat_rst_req;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  lvl_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .src_req(src_req), .btn_pressed(btn_pressed),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_rdata(bus_rdata), .irq_out(irq_out), .top_idx(top_idx),
    .top_valid(top_valid), .plat_rst_req(plat_rst_req)
  );

  localparam int NV = 6;
  localparam logic [31:0] V_SRC [NV] = '{32'h0000_0001, 32'h8000_0000, 32'hF000_0F00,
                                         32'h0000_0C08, 32'h0000_0000, 32'h0000_0006};
  localparam logic [31:0] V_MSK [NV] = '{32'h0000_0001, 32'h8000_0000, 32'h0F00_F000,
                                         32'hFFFE_FFFD, 32'h0001_0000, 32'h0000_0006};
  localparam logic [31:0] V_CSE [NV] = '{32'h0001_0001, 32'h8001_0000, 32'hF001_0F00,
                                         32'h0001_0C08, 32'h0001_0000, 32'h0001_0004};
  localparam logic        V_IRQ [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam logic [4:0]  V_IDX [NV] = '{5'd0, 5'd31, 5'd0, 5'd3, 5'd16, 5'd2};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    rd(8'h04, v); chk(v == 0, "R9 mask after reset", v, 0);
    chk(irq_out == 0 && plat_rst_req == 0, "R9 outputs after reset", {irq_out, plat_rst_req}, 0);
    rd(8'h00, v); chk(v == 32'h0001_0000, "R9 cause after reset", v, 32'h0001_0000);

    // Vector table: R2 R6 R7
    for (int i = 0; i < NV; i++) begin
      src_req = V_SRC[i];
      wr(8'h04, V_MSK[i], 4'hF);
      rd(8'h00, v); chk(v == V_CSE[i], "R2 cause vector", v, V_CSE[i]);
      chk(irq_out == V_IRQ[i], "R6 irq vector", 32'(irq_out), 32'(V_IRQ[i]));
      chk(top_valid == V_IRQ[i], "R7 valid vector", 32'(top_valid), 32'(V_IRQ[i]));
      if (V_IRQ[i]) chk(top_idx == V_IDX[i], "R7 index vector", 32'(top_idx), 32'(V_IDX[i]));
    end

    // R2 self-clearing when the request drops
    src_req = 32'h0000_0008; wr(8'h04, 32'h0000_0008, 4'hF);
    chk(irq_out == 1, "R2 level asserted", 32'(irq_out), 1);
    src_req = 0; #1;
    chk(irq_out == 0, "R2 level dropped", 32'(irq_out), 0);

    // R1 byte strobes
    wr(8'h04, 32'h0, 4'hF);
    wr(8'h04, 32'hFFFF_FFFF, 4'b0101);
    rd(8'h04, v); chk(v == 32'h00FF_00FF, "R1 byte strobe lanes", v, 32'h00FF_00FF);
    wr(8'h04, 32'hA5C3_3C5A, 4'b1010);
    rd(8'h04, v); chk(v == 32'hA5FF_3CFF, "R1 upper lanes", v, 32'hA5FF_3CFF);

    // R3 write ones to level bits
    src_req = 32'h0000_0100;
    wr(8'h00, 32'hFFFF_FFFF, 4'hF);
    rd(8'h00, v); chk(v == 32'h0001_0100, "R3 level bits unaffected", v, 32'h0001_0100);
    src_req = 0;

    // R4 R5 button capture
    wr(8'h04, 32'h0000_0002, 4'hF);
    btn_pressed = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(8'h00, v);
    chk(v[1] == 0, "R4 sticky not yet set after two edges", 32'(v[1]), 0);
    chk(v[16] == 0, "R5 live bit reads pressed", 32'(v[16]), 0);
    @(negedge clk);
    rd(8'h00, v); chk(v[1] == 1, "R4 sticky set on third edge", 32'(v[1]), 1);
    chk(irq_out == 1 && top_idx == 5'd1, "R4 sticky raises irq idx 1", {27'd0, top_idx}, 1);
    btn_pressed = 1'b0;
    repeat (4) @(negedge clk);
    rd(8'h00, v);
    chk(v[1] == 1, "R4 sticky holds after release", 32'(v[1]), 1);
    chk(v[16] == 1, "R5 live bit reads released", 32'(v[16]), 1);
    wr(8'h00, 32'h0000_0002, 4'b1110);
    rd(8'h00, v); chk(v[1] == 1, "R4 clear needs lane 0 strobe", 32'(v[1]), 1);
    wr(8'h00, 32'hFFFF_FFFD, 4'hF);
    rd(8'h00, v); chk(v[1] == 1, "R4 clear needs bit 1 set", 32'(v[1]), 1);
    wr(8'h00, 32'h0000_0002, 4'b0001);
    rd(8'h00, v); chk(v[1] == 0, "R4 cleared by write one", 32'(v[1]), 0);
    chk(irq_out == 0, "R4 irq gone after clear", 32'(irq_out), 0);

    // R8 reset request
    wr(8'h24, 32'h0000_0055, 4'hF);
    chk(plat_rst_req == 0, "R8 nonzero data no pulse", 32'(plat_rst_req), 0);
    wr(8'h24, 32'h0000_0000, 4'b0001);
    chk(plat_rst_req == 1, "R8 pulse after zero write", 32'(plat_rst_req), 1);
    @(negedge clk);
    chk(plat_rst_req == 0, "R8 pulse lasts one cycle", 32'(plat_rst_req), 0);
    rd(8'h24, v); chk(v == 0, "R8 reset reg reads zero", v, 0);

    // R10 quiesce
    src_req = 32'hFFFF_FFFF;
    wr(8'h04, 32'hFFFF_FFFF, 4'hF);
    chk(irq_out == 1, "R10 irq before quiesce", 32'(irq_out), 1);
    wr(8'h04, 32'h0, 4'hF);
    wr(8'h00, 32'hFFFF_FFFF, 4'hF);
    chk(irq_out == 0 && top_valid == 0, "R10 nothing pending", {irq_out, top_valid}, 0);

    // R9 reset mid-run clears mask and sticky
    src_req = 0;
    wr(8'h04, 32'h0000_0003, 4'hF);
    btn_pressed = 1'b1;
    repeat (4) @(negedge clk);
    btn_pressed = 1'b0;
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    rd(8'h04, v); chk(v == 0, "R9 mask cleared by reset", v, 0);
    rd(8'h00, v); chk(v[1] == 0, "R9 sticky cleared by reset", 32'(v[1]), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule